// File: doc/BRIEF.md
# Addressed serial control register for a current-output driver

This block is the digital front end of a programmable current-output driver. A host sends 16-bit command words over a three-wire serial link (serial clock, data, active-low select). Each word carries a board address, an output-enable bit, a 4-bit range code and a self-clearing reset bit. The block accepts a word only when its address matches the strap pins, its reserved bits are zero and exactly sixteen bits were framed. An accepted word updates the enable and the range together.

A mode strap chooses the source of the settings. In software mode they come from the serial register, and a level-sensitive active-low reset pin can hold the register at zero. In hardware mode the enable and the range come straight from pins, and the reset pin has no effect. A clear request is raised whenever the effective output is enabled while the clear input is high.

Top module: `cdrv_ctrl_top`

## Requirements
- R1: Data is sampled MSB first on each falling edge of sclk_i while cs_ni is low. When cs_ni rises, the word is decoded only if exactly 16 falling edges were seen in that frame. A frame of any other length is discarded.
- R2: A word is accepted only when bits [15:13] equal addr_i.
- R3: A word with any of bits 11, 1 or 0 set is rejected, and the register is left unchanged.
- R4: After power-on reset (rst_ni low), in software mode out_en_o is 0, range_o is 0 and clear_o is 0.
- R5: An accepted word with bit 6 clear sets the enable to bit 12 and the range to bits [10:7], both in the same update.
- R6: An accepted word with bit 6 set returns the enable and the range to 0, whatever its other bits hold.
- R7: In software mode, while rst_pin_ni is low, the enable and the range are held at 0 and serial words are ignored.
- R8: clear_o equals clear_i AND out_en_o.
- R9: With hw_mode_i high, out_en_o follows en_pin_i and range_o follows rng_pins_i. rst_pin_ni has no effect, and serial words do not change the software register.
- R10: Bits [5:2] of a word have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| hw_mode_i | input | 1 | 1 = hardware (pin) control, 0 = software (serial) control |
| addr_i | input | 3 | Board address strap |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| rst_pin_ni | input | 1 | Level-sensitive active-low reset pin (software mode only) |
| clear_i | input | 1 | Clear request input |
| en_pin_i | input | 1 | Output enable pin for hardware mode |
| rng_pins_i | input | 4 | Range pins for hardware mode |
| out_en_o | output | 1 | Effective output enable |
| range_o | output | 4 | Effective range code |
| clear_o | output | 1 | Clear state request |

## Verification
The hardest case to reach is a serial word that arrives while the register must not change. This covers a frame one bit short or one bit long, a word sent during hardware mode, and a word sent while the reset pin is held low. In each case the stimulus first loads a known non-zero setting, then sends the word that must be ignored. Only after that does it return to a state where the register is visible at the outputs, so a wrongly accepted word shows up. Random words, with the address field and the reserved bits biased toward legal values, mix accepted and rejected writes against a bench model.

// File: rtl/cdrv_pkg.sv
package cdrv_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned RNG_W  = 4;

  // field positions, fixed by the host-side protocol
  localparam int unsigned ADDR_LSB = WORD_W - ADDR_W;  // 13
  localparam int unsigned EN_BIT   = 12;
  localparam int unsigned RSV_HI   = 11;
  localparam int unsigned RNG_LSB  = 7;
  localparam int unsigned RST_BIT  = 6;
  localparam int unsigned RSV_LO_W = 2;                // bits 1:0

  typedef struct packed {
    logic             en;
    logic [RNG_W-1:0] rng;
  } ctl_t;
endpackage

// File: rtl/cdrv_sync.sv
module cdrv_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= RST_VAL;
        else         st_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= RST_VAL;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cdrv_shift.sv
module cdrv_shift
  import cdrv_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_s_i,
  input  logic         cs_n_s_i,
  input  logic         sdi_s_i,
  output logic         word_vld_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CNT_W   = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(W);

  logic             sclk_q, cs_q;
  logic             fall, cs_rise;
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;

  assign fall    = sclk_q & ~sclk_s_i;
  assign cs_rise = ~cs_q & cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_n_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cs_n_s_i) begin
      cnt_q <= '0;
    end else if (fall) begin
      sh_q  <= {sh_q[W-2:0], sdi_s_i};
      cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= cs_rise && (cnt_q == CNT_OK);
      if (cs_rise) word_o <= sh_q;
    end
  end

  assert_idle_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (cnt_q == '0));
  assert_vld_framed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(!cs_q && cs_n_s_i));
endmodule

// File: rtl/cdrv_regs.sv
module cdrv_regs
  import cdrv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hw_mode_i,
  input  logic              rst_pin_s_i,
  output ctl_t              ctl_o
);
  logic addr_hit, rsv_ok, accept, pin_rst;
  ctl_t ctl_q;

  assign addr_hit = (word_i[WORD_W-1:ADDR_LSB] == addr_i);
  assign rsv_ok   = !word_i[RSV_HI] && (word_i[RSV_LO_W-1:0] == '0);
  assign pin_rst  = !hw_mode_i && !rst_pin_s_i;
  assign accept   = word_vld_i && !hw_mode_i && !pin_rst && addr_hit && rsv_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (pin_rst) begin
      ctl_q <= '0;
    end else if (accept) begin
      if (word_i[RST_BIT]) ctl_q <= '0;   // self-clearing reset command
      else begin
        ctl_q.en  <= word_i[EN_BIT];
        ctl_q.rng <= word_i[RNG_LSB +: RNG_W];
      end
    end
  end

  assign ctl_o = ctl_q;

  assert_rsv_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && !rsv_ok && !pin_rst) |=> $stable(ctl_q));
  assert_pin_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rst |=> (ctl_q == '0));
  assert_hw_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_mode_i && $past(hw_mode_i)) |-> $stable(ctl_q));
  assert_cmd_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && word_i[RST_BIT]) |=> (ctl_q == '0));
endmodule

// File: rtl/cdrv_ctrl_top.sv
module cdrv_ctrl_top
  import cdrv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  input  logic              rst_pin_ni,
  input  logic              clear_i,
  input  logic              en_pin_i,
  input  logic [RNG_W-1:0]  rng_pins_i,
  output logic              out_en_o,
  output logic [RNG_W-1:0]  range_o,
  output logic              clear_o
);
  logic [3:0]        raw_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  ctl_t              ctl;

  // order: rst_pin, cs_n, sclk, sdi
  cdrv_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_pin_ni, cs_ni, sclk_i, sdi_i}),
    .q_o   (raw_s)
  );

  cdrv_shift #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (raw_s[1]),
    .cs_n_s_i  (raw_s[2]),
    .sdi_s_i   (raw_s[0]),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  cdrv_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_vld_i (word_vld),
    .word_i     (word),
    .addr_i     (addr_i),
    .hw_mode_i  (hw_mode_i),
    .rst_pin_s_i(raw_s[3]),
    .ctl_o      (ctl)
  );

  assign out_en_o = hw_mode_i ? en_pin_i   : ctl.en;
  assign range_o  = hw_mode_i ? rng_pins_i : ctl.rng;
  assign clear_o  = out_en_o & clear_i;

  always_comb begin
    if (rst_ni && !clear_i) assert_clr_gate_R8: assert (!clear_o);
  end
  assert_sw_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_mode_i && !ctl.en) |-> !clear_o);
endmodule

// File: tb/cdrv_ctrl_top_tb.sv
module cdrv_ctrl_top_tb;
  localparam int CLK_P = 10;
  localparam logic [2:0] MY_ADDR = 3'b101;

  logic clk = 0, rst_ni = 0, hw_mode = 0, sclk = 1, cs_n = 1, sdi = 0;
  logic rst_pin_n = 1, clear = 0, en_pin = 0;
  logic [3:0] rng_pins = 0;
  logic out_en, clr_o;
  logic [3:0] rng_o;

  int n_run = 0, n_fail = 0;
  logic exp_en = 0;
  logic [3:0] exp_rng = 0;

  always #(CLK_P/2) clk = ~clk;

  cdrv_ctrl_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_mode_i(hw_mode), .addr_i(MY_ADDR),
    .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi), .rst_pin_ni(rst_pin_n),
    .clear_i(clear), .en_pin_i(en_pin), .rng_pins_i(rng_pins),
    .out_en_o(out_en), .range_o(rng_o), .clear_o(clr_o)
  );

  function automatic logic takes(logic [15:0] w, int nb);
    return nb == 16 && w[15:13] == MY_ADDR && !w[11] && w[1:0] == 2'b00;
  endfunction

  function automatic logic [15:0] mk(logic [2:0] a, logic en, logic [3:0] r, logic rb);
    return {a, en, 1'b0, r, rb, 4'b1010, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag);
    chk({tag, " en"}, out_en, exp_en);
    chk({tag, " range"}, rng_o, exp_rng);
    chk({tag, " clear R8"}, clr_o, exp_en & clear);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // nb bits, MSB of the low nb bits of w first (extra bits beyond 16 are zero)
  task automatic send(logic [15:0] w, int nb);
    cs_n = 0; idle(4);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = (i < 16) ? w[i] : 1'b0;
      sclk = 1; idle(4);
      sclk = 0; idle(4);
    end
    sclk = 1; idle(4);
    cs_n = 1; idle(12);
  endtask

  task automatic model(logic [15:0] w, int nb);
    if (takes(w, nb)) begin
      if (w[6]) begin exp_en = 0; exp_rng = 0; end
      else begin exp_en = w[12]; exp_rng = w[10:7]; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int nb;
    void'($urandom(32'h5eed_1234));
    idle(3);
    chk_out("R4 reset");
    rst_ni = 1; idle(4);
    chk_out("R4 after reset");

    w = mk(MY_ADDR, 1, 4'h9, 0); send(w, 16); model(w, 16);
    chk_out("R5 write");
    chk("R5 en set", out_en, 1);
    clear = 1; idle(1); chk("R8 clear high", clr_o, 1);
    clear = 0; idle(1); chk("R8 clear low", clr_o, 0);

    send(mk(3'b100, 0, 4'h3, 0), 16);
    chk_out("R2 addr mismatch");
    send(mk(MY_ADDR, 0, 4'h3, 0) | 16'h0800, 16); chk_out("R3 bit11");
    send(mk(MY_ADDR, 0, 4'h3, 0) | 16'h0002, 16); chk_out("R3 bit1");
    send(mk(MY_ADDR, 0, 4'h3, 0) | 16'h0001, 16); chk_out("R3 bit0");

    send(mk(MY_ADDR, 0, 4'h3, 0), 15); chk_out("R1 short frame");
    send(mk(MY_ADDR, 0, 4'h3, 0), 17); chk_out("R1 long frame");

    w = mk(MY_ADDR, 1, 4'h6, 0) ^ 16'h003C; send(w, 16); model(w, 16);
    chk("R10 range", rng_o, 4'h6);
    chk_out("R10 dont care");

    w = mk(MY_ADDR, 1, 4'hF, 1); send(w, 16); model(w, 16);
    chk("R6 cmd reset en", out_en, 0);
    chk("R6 cmd reset range", rng_o, 0);

    w = mk(MY_ADDR, 1, 4'hA, 0); send(w, 16); model(w, 16);
    rst_pin_n = 0; idle(6);
    exp_en = 0; exp_rng = 0;
    chk_out("R7 pin held");
    send(mk(MY_ADDR, 1, 4'h5, 0), 16);
    rst_pin_n = 1; idle(6);
    chk_out("R7 write ignored");

    w = mk(MY_ADDR, 1, 4'h2, 0); send(w, 16); model(w, 16);
    hw_mode = 1; en_pin = 1; rng_pins = 4'hC; idle(2);
    chk("R9 hw en", out_en, 1);
    chk("R9 hw range", rng_o, 4'hC);
    rst_pin_n = 0; idle(6);
    chk("R9 pin rst no effect", out_en, 1);
    send(mk(MY_ADDR, 0, 4'h7, 0), 16);
    rst_pin_n = 1; en_pin = 0; rng_pins = 4'h1; idle(2);
    chk("R9 hw follow", {out_en, rng_o}, {1'b0, 4'h1});
    hw_mode = 0; idle(2);
    chk_out("R9 sw reg kept");

    for (int k = 0; k < 60; k++) begin
      w = 16'($urandom);
      if ($urandom % 2) w[15:13] = MY_ADDR;
      if ($urandom % 10 < 7) begin w[11] = 0; w[1:0] = 0; end
      w[6] = ($urandom % 100 < 15);
      nb = ($urandom % 10 == 0) ? 15 + 2 * ($urandom % 2) : 16;
      clear = $urandom % 2;
      send(w, nb); model(w, nb);
      chk_out("R1 R2 R3 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule